// File: doc/BRIEF.md
# Multiport Frame Steering Matcher with Ingress Timestamps

This block looks at the header of every frame that a switch port receives. It compares the destination MAC address and the EtherType against a small set of programmable steering entries. Each entry has a compare mode, a 48-bit address with a 16-bit EtherType, and a port bitmask. When an entry matches, the block outputs that entry's bitmask one cycle after the header. The switch fabric then delivers the frame to every port whose bit is set, for example a host-facing port used for precision time traffic.

The block also runs a nanosecond clock. This clock adds a fixed step every cycle and returns to zero after the last value of one second. When a port signals the first byte of a frame, the clock value is latched for that port. If the winning entry has stamping turned on, the ingress port is allowed to stamp, and reporting is turned on, the latched value and the port number go out on a valid/ready report channel.

The configuration is written through a simple write-only port. One write carries a 6-bit word address and 64 bits of data.

Top module: `mport_steer`

## Requirements
- R1: The mode field of an entry selects how it compares. Value 0 never matches. Value 1 compares `hdr_dmac` with bits 47:0 of the entry's match word at address 16+i. Value 2 compares `hdr_etype` with bits 63:48 of that word. Value 3 requires both to be equal.
- R2: Each control word holds four entries. Entry i has its mode in the word at address i/4, in bits 4*(i%4)+1 down to 4*(i%4).
- R3: When several entries match the same header, the entry with the lowest index wins.
- R4: One cycle after `hdr_valid`, `fwd_valid` is high for exactly one cycle. On a match, `fwd_hit` is 1, `fwd_entry` is the winning index, and `fwd_vec` is the vector written at address 32+i. On a miss, `fwd_hit` is 0 and `fwd_vec` is 0.
- R5: Stamping for entry 0 is enabled by bit 15 of control word 0. Stamping for every other entry i is enabled by bit 4*(i%4)+2 of control word i/4. A match on an entry whose enable is clear produces no report.
- R6: Address 4 holds a port mask with one bit per ingress port. A frame from a port whose mask bit is clear produces no report, whichever entry it matches.
- R7: Bit 0 at address 5 enables reporting. While it is clear, matching and forwarding continue unchanged, but no report is produced.
- R8: The reported time is the clock value present at the clock edge where `sof_valid` was sampled for that port. The report appears on the same edge as `fwd_valid` and carries `rpt_port` = `hdr_port`.
- R9: After reset the clock is 0 and adds INC_NS on every cycle. When the next step would pass WRAP_NS (default 999,999,999), the clock continues from the remainder, so it never exceeds WRAP_NS.
- R10: While `rpt_valid` is high and `rpt_ready` is low, the report holds its port and time, and a new eligible stamp is dropped. A report that is accepted with no new stamp clears `rpt_valid`.
- R11: When a report is accepted in the same cycle as a new eligible stamp, the new report is loaded and `rpt_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 64 | Configuration write data |
| sof_valid | input | 1 | First byte of a frame seen on `sof_port` |
| sof_port | input | 3 | Ingress port of the frame start |
| hdr_valid | input | 1 | Header fields are valid |
| hdr_port | input | 3 | Ingress port of the header |
| hdr_dmac | input | 48 | Destination MAC address |
| hdr_etype | input | 16 | EtherType |
| fwd_valid | output | 1 | Steering result valid |
| fwd_hit | output | 1 | An entry matched |
| fwd_entry | output | 3 | Winning entry index |
| fwd_vec | output | 32 | Destination port bitmask |
| rpt_valid | output | 1 | Timestamp report pending |
| rpt_ready | input | 1 | Report accepted by the consumer |
| rpt_port | output | 3 | Ingress port of the stamped frame |
| rpt_time | output | 32 | Captured nanosecond value |

## Verification
The report register can receive a new eligible stamp in the same cycle that the consumer accepts the pending report. The bench first holds `rpt_ready` low across a second eligible frame and checks that this frame is dropped. It then raises `rpt_ready` on the same edge as the next header, and judges the result by the port and time of the report that follows: they must come from the newer frame. Clock wrap is forced with a short wrap parameter, by stamping two ports on the two edges either side of the wrap.

// File: rtl/mpx_pkg.sv
package mpx_pkg;
   typedef enum logic [1:0] {
      MODE_OFF   = 2'd0,
      MODE_ADDR  = 2'd1,
      MODE_ETYPE = 2'd2,
      MODE_BOTH  = 2'd3
   } cmp_mode_e;

   localparam int ADDR_W = 6;
   localparam logic [ADDR_W-1:0] A_PMASK     = 6'd4;
   localparam logic [ADDR_W-1:0] A_RPT_CTRL  = 6'd5;
   localparam logic [ADDR_W-1:0] A_MATCH_BASE = 6'd16;
   localparam logic [ADDR_W-1:0] A_VEC_BASE  = 6'd32;
endpackage

// File: rtl/mpx_regs.sv
module mpx_regs
   import mpx_pkg::*;
#(
   parameter int N_ENTRY = 6,
   parameter int N_PORT  = 8,
   parameter int VEC_W   = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            we,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [63:0]                     wdata,
   output logic [N_ENTRY-1:0][1:0]         mode_o,
   output logic [N_ENTRY-1:0]              ts_en_o,
   output logic [N_ENTRY-1:0][47:0]        mac_o,
   output logic [N_ENTRY-1:0][15:0]        etype_o,
   output logic [N_ENTRY-1:0][VEC_W-1:0]   vec_o,
   output logic [N_PORT-1:0]               pmask_o,
   output logic                            rpt_en_o
);
   localparam int N_GRP = (N_ENTRY + 3) / 4;

   if (N_ENTRY < 1 || N_ENTRY > 16) begin : g_bad_entries
      $error("mpx_regs: N_ENTRY must lie in 1..16");
   end
   if (N_PORT < 2 || N_PORT > 16) begin : g_bad_ports
      $error("mpx_regs: N_PORT must lie in 2..16");
   end
   if (VEC_W < 1 || VEC_W > 64) begin : g_bad_vec
      $error("mpx_regs: VEC_W must lie in 1..64");
   end

   logic [N_GRP-1:0][15:0]          ctrl_q;
   logic [N_ENTRY-1:0][63:0]        match_q;
   logic [N_ENTRY-1:0][VEC_W-1:0]   vec_q;
   logic [N_PORT-1:0]               pmask_q;
   logic                            rpt_en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         match_q  <= '0;
         vec_q    <= '0;
         pmask_q  <= '0;
         rpt_en_q <= 1'b0;
      end else if (we) begin
         for (int g = 0; g < N_GRP; g++)
            if (addr == ADDR_W'(g)) ctrl_q[g] <= wdata[15:0];
         if (addr == A_PMASK)    pmask_q  <= wdata[N_PORT-1:0];
         if (addr == A_RPT_CTRL) rpt_en_q <= wdata[0];
         for (int i = 0; i < N_ENTRY; i++) begin
            if (addr == A_MATCH_BASE + ADDR_W'(i)) match_q[i] <= wdata;
            if (addr == A_VEC_BASE + ADDR_W'(i))   vec_q[i]   <= wdata[VEC_W-1:0];
         end
      end
   end

   for (genvar i = 0; i < N_ENTRY; i++) begin : g_ent
      localparam int GRP  = i / 4;
      localparam int SLOT = i % 4;
      assign mode_o[i]  = ctrl_q[GRP][4*SLOT +: 2];
      assign mac_o[i]   = match_q[i][47:0];
      assign etype_o[i] = match_q[i][63:48];
      assign vec_o[i]   = vec_q[i];
      if (i == 0) begin : g_ts_first
         assign ts_en_o[i] = ctrl_q[0][15];
      end else begin : g_ts_rest
         assign ts_en_o[i] = ctrl_q[GRP][4*SLOT+2];
      end
   end

   assign pmask_o  = pmask_q;
   assign rpt_en_o = rpt_en_q;
endmodule

// File: rtl/mpx_ns_clock.sv
module mpx_ns_clock #(
   parameter int              N_PORT  = 8,
   parameter int              TS_W    = 32,
   parameter longint unsigned WRAP_NS = 999_999_999,
   parameter longint unsigned INC_NS  = 20,
   localparam int             PORT_W  = $clog2(N_PORT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof_valid,
   input  logic [PORT_W-1:0] sof_port,
   input  logic [PORT_W-1:0] rd_port,
   output logic [TS_W-1:0]   rd_time
);
   localparam logic [TS_W-1:0] WRAP      = TS_W'(WRAP_NS);
   localparam logic [TS_W-1:0] INC       = TS_W'(INC_NS);
   localparam logic [TS_W-1:0] LAST_STEP = WRAP - INC;

   if (INC_NS == 0 || INC_NS > WRAP_NS) begin : g_bad_inc
      $error("mpx_ns_clock: INC_NS must lie in 1..WRAP_NS");
   end
   if (TS_W < 64 && WRAP_NS >= (64'd1 << TS_W)) begin : g_bad_wrap
      $error("mpx_ns_clock: WRAP_NS does not fit in TS_W bits");
   end

   logic [TS_W-1:0]              cnt_q;
   logic [N_PORT-1:0][TS_W-1:0]  stamp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         stamp_q <= '0;
      end else begin
         cnt_q <= (cnt_q > LAST_STEP) ? cnt_q - LAST_STEP - 1'b1 : cnt_q + INC;
         if (sof_valid) stamp_q[sof_port] <= cnt_q;
      end
   end

   assign rd_time = stamp_q[rd_port];

   assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= WRAP);

   assert_cnt_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q < $past(cnt_q)) |-> ($past(cnt_q) > LAST_STEP));
endmodule

// File: rtl/mpx_match.sv
module mpx_match
   import mpx_pkg::*;
#(
   parameter int  N_ENTRY = 6,
   parameter int  VEC_W   = 32,
   localparam int ENT_W   = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
   input  logic [N_ENTRY-1:0][1:0]        mode_i,
   input  logic [N_ENTRY-1:0][47:0]       mac_i,
   input  logic [N_ENTRY-1:0][15:0]       etype_i,
   input  logic [N_ENTRY-1:0][VEC_W-1:0]  vec_i,
   input  logic [N_ENTRY-1:0]             ts_en_i,
   input  logic [47:0]                    dmac,
   input  logic [15:0]                    etype,
   output logic                           hit_o,
   output logic [ENT_W-1:0]               idx_o,
   output logic [VEC_W-1:0]               vec_o,
   output logic                           ts_o
);
   logic [N_ENTRY-1:0] ent_hit;

   for (genvar i = 0; i < N_ENTRY; i++) begin : g_cmp
      logic mac_eq, type_eq;
      assign mac_eq  = (dmac == mac_i[i]);
      assign type_eq = (etype == etype_i[i]);
      always_comb begin
         unique case (cmp_mode_e'(mode_i[i]))
            MODE_ADDR:  ent_hit[i] = mac_eq;
            MODE_ETYPE: ent_hit[i] = type_eq;
            MODE_BOTH:  ent_hit[i] = mac_eq & type_eq;
            default:    ent_hit[i] = 1'b0;
         endcase
      end
   end

   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      vec_o = '0;
      ts_o  = 1'b0;
      for (int i = N_ENTRY - 1; i >= 0; i--) begin
         if (ent_hit[i]) begin
            hit_o = 1'b1;
            idx_o = ENT_W'(i);
            vec_o = vec_i[i];
            ts_o  = ts_en_i[i];
         end
      end
   end

   always_comb begin
      if (hit_o) begin
         assert_winner_hits_R3: assert (ent_hit[idx_o]);
         assert_no_lower_hit_R3: assert ((ent_hit & ((N_ENTRY'(1) << idx_o) - 1'b1)) == '0);
      end else begin
         assert_miss_empty_R1: assert (ent_hit == '0);
      end
   end
endmodule

// File: rtl/mpx_ts_report.sv
module mpx_ts_report #(
   parameter int PORT_W = 3,
   parameter int TS_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [PORT_W-1:0] push_port,
   input  logic [TS_W-1:0]   push_time,
   output logic              rpt_valid,
   input  logic              rpt_ready,
   output logic [PORT_W-1:0] rpt_port,
   output logic [TS_W-1:0]   rpt_time
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rpt_valid <= 1'b0;
         rpt_port  <= '0;
         rpt_time  <= '0;
      end else if (push && (!rpt_valid || rpt_ready)) begin
         rpt_valid <= 1'b1;
         rpt_port  <= push_port;
         rpt_time  <= push_time;
      end else if (rpt_ready) begin
         rpt_valid <= 1'b0;
      end
   end

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_valid && !rpt_ready) |=> (rpt_valid && $stable(rpt_port) && $stable(rpt_time)));

   assert_swap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_valid && rpt_ready && push) |=> (rpt_valid && rpt_time == $past(push_time)));
endmodule

// File: rtl/mport_steer.sv
module mport_steer
   import mpx_pkg::*;
#(
   parameter int              N_ENTRY = 6,
   parameter int              N_PORT  = 8,
   parameter int              VEC_W   = 32,
   parameter int              TS_W    = 32,
   parameter longint unsigned WRAP_NS = 999_999_999,
   parameter longint unsigned INC_NS  = 20,
   localparam int             PORT_W  = $clog2(N_PORT),
   localparam int             ENT_W   = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [63:0]       cfg_wdata,
   input  logic              sof_valid,
   input  logic [PORT_W-1:0] sof_port,
   input  logic              hdr_valid,
   input  logic [PORT_W-1:0] hdr_port,
   input  logic [47:0]       hdr_dmac,
   input  logic [15:0]       hdr_etype,
   output logic              fwd_valid,
   output logic              fwd_hit,
   output logic [ENT_W-1:0]  fwd_entry,
   output logic [VEC_W-1:0]  fwd_vec,
   output logic              rpt_valid,
   input  logic              rpt_ready,
   output logic [PORT_W-1:0] rpt_port,
   output logic [TS_W-1:0]   rpt_time
);
   logic [N_ENTRY-1:0][1:0]        mode;
   logic [N_ENTRY-1:0]             ts_en;
   logic [N_ENTRY-1:0][47:0]       mac;
   logic [N_ENTRY-1:0][15:0]       etype;
   logic [N_ENTRY-1:0][VEC_W-1:0]  vec;
   logic [N_PORT-1:0]              pmask;
   logic                           rpt_en;

   logic                m_hit, m_ts;
   logic [ENT_W-1:0]    m_idx;
   logic [VEC_W-1:0]    m_vec;
   logic [TS_W-1:0]     port_time;
   logic                push;

   mpx_regs #(.N_ENTRY(N_ENTRY), .N_PORT(N_PORT), .VEC_W(VEC_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .mode_o(mode), .ts_en_o(ts_en), .mac_o(mac), .etype_o(etype), .vec_o(vec),
      .pmask_o(pmask), .rpt_en_o(rpt_en));

   mpx_ns_clock #(.N_PORT(N_PORT), .TS_W(TS_W), .WRAP_NS(WRAP_NS), .INC_NS(INC_NS)) clk_i (
      .clk(clk), .rst_n(rst_n), .sof_valid(sof_valid), .sof_port(sof_port),
      .rd_port(hdr_port), .rd_time(port_time));

   mpx_match #(.N_ENTRY(N_ENTRY), .VEC_W(VEC_W)) match_i (
      .mode_i(mode), .mac_i(mac), .etype_i(etype), .vec_i(vec), .ts_en_i(ts_en),
      .dmac(hdr_dmac), .etype(hdr_etype),
      .hit_o(m_hit), .idx_o(m_idx), .vec_o(m_vec), .ts_o(m_ts));

   assign push = hdr_valid & m_hit & m_ts & pmask[hdr_port] & rpt_en;

   mpx_ts_report #(.PORT_W(PORT_W), .TS_W(TS_W)) rpt_i (
      .clk(clk), .rst_n(rst_n), .push(push), .push_port(hdr_port), .push_time(port_time),
      .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_port(rpt_port), .rpt_time(rpt_time));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_valid <= 1'b0;
         fwd_hit   <= 1'b0;
         fwd_entry <= '0;
         fwd_vec   <= '0;
      end else begin
         fwd_valid <= hdr_valid;
         if (hdr_valid) begin
            fwd_hit   <= m_hit;
            fwd_entry <= m_idx;
            fwd_vec   <= m_vec;
         end
      end
   end

   assert_fwd_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> $past(hdr_valid));

   assert_miss_no_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && !fwd_hit) |-> (fwd_vec == '0));

   assert_rpt_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rpt_valid) |-> ($past(rpt_en) && $past(hdr_valid)));
endmodule

// File: tb/mport_steer_tb_top.sv
module mport_steer_tb_top;
   localparam longint unsigned WRAP = 199;
   localparam longint unsigned INC  = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_addr = '0;
   logic [63:0] cfg_wdata = '0;
   logic        sof_valid = 1'b0;
   logic [2:0]  sof_port = '0;
   logic        hdr_valid = 1'b0;
   logic [2:0]  hdr_port = '0;
   logic [47:0] hdr_dmac = '0;
   logic [15:0] hdr_etype = '0;
   logic        rpt_ready = 1'b1;
   logic        fwd_valid, fwd_hit, rpt_valid;
   logic [2:0]  fwd_entry, rpt_port;
   logic [31:0] fwd_vec, rpt_time;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;
   logic [31:0] m_ns;

   always #10 clk = ~clk;

   mport_steer #(.WRAP_NS(WRAP), .INC_NS(INC)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .sof_valid(sof_valid), .sof_port(sof_port), .hdr_valid(hdr_valid), .hdr_port(hdr_port),
      .hdr_dmac(hdr_dmac), .hdr_etype(hdr_etype), .fwd_valid(fwd_valid), .fwd_hit(fwd_hit),
      .fwd_entry(fwd_entry), .fwd_vec(fwd_vec), .rpt_valid(rpt_valid), .rpt_ready(rpt_ready),
      .rpt_port(rpt_port), .rpt_time(rpt_time));

   // Reference nanosecond clock taken from R9.
   always @(posedge clk) begin
      if (!rst_n) m_ns <= 32'd0;
      else if (64'(m_ns) + INC > WRAP) m_ns <= 32'(64'(m_ns) + INC - WRAP - 1);
      else m_ns <= m_ns + 32'(INC);
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [63:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // {port, dmac, etype, hit, entry, vec, stamp}
   localparam int VW = 104;
   localparam int NV = 9;
   localparam logic [VW-1:0] VECS [NV] = '{
      {3'd0, 48'h020000000001, 16'h88F7, 1'b1, 3'd0, 32'h00000100, 1'b1},
      {3'd1, 48'h0180C200000E, 16'h0800, 1'b1, 3'd1, 32'h00000003, 1'b1},
      {3'd2, 48'hAABBCCDDEEFF, 16'h0800, 1'b1, 3'd2, 32'h00000010, 1'b0},
      {3'd2, 48'hAABBCCDDEEFF, 16'h0806, 1'b0, 3'd0, 32'h00000000, 1'b0},
      {3'd3, 48'h112233445566, 16'h1234, 1'b0, 3'd0, 32'h00000000, 1'b0},
      {3'd4, 48'h000000000055, 16'h0800, 1'b1, 3'd5, 32'h80000000, 1'b0},
      {3'd5, 48'hAABBCCDDEEFF, 16'h88F7, 1'b1, 3'd0, 32'h00000100, 1'b0},
      {3'd3, 48'h0180C200000E, 16'h88F7, 1'b1, 3'd0, 32'h00000100, 1'b1},
      {3'd2, 48'h000000000055, 16'h0800, 1'b1, 3'd5, 32'h80000000, 1'b1}
   };

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] t_a, t_b;
      repeat (3) @(negedge clk);
      chk(!fwd_valid, "reset fwd_valid R4", 64'(fwd_valid), 0);
      chk(!rpt_valid, "reset rpt_valid R10", 64'(rpt_valid), 0);
      rst_n = 1'b1;

      // Before configuration every mode is 0, so nothing matches (R1).
      @(negedge clk);
      hdr_valid = 1'b1; hdr_port = 3'd0; hdr_dmac = 48'h0; hdr_etype = 16'h0;
      @(negedge clk);
      hdr_valid = 1'b0;
      chk(fwd_valid && !fwd_hit && fwd_vec == 0, "R1 disabled after reset", 64'(fwd_hit), 0);

      // Configuration: entry modes and stamp enables (R2, R5).
      wr(6'd0, 64'h8352);
      wr(6'd1, 64'h0056);
      wr(6'd16, {16'h88F7, 48'h0});
      wr(6'd17, {16'h0000, 48'h0180C200000E});
      wr(6'd18, {16'h0800, 48'hAABBCCDDEEFF});
      wr(6'd19, {16'h1234, 48'h112233445566});
      wr(6'd20, {16'h88F7, 48'h0});
      wr(6'd21, {16'h0000, 48'h000000000055});
      wr(6'd32, 64'h100);
      wr(6'd33, 64'h3);
      wr(6'd34, 64'h10);
      wr(6'd35, 64'h20);
      wr(6'd36, 64'h40);
      wr(6'd37, 64'h80000000);
      wr(6'd4, 64'h0F);
      wr(6'd5, 64'h1);

      // Table walk: R1 R2 R3 R4 R5 R6 R8
      for (int v = 0; v < NV; v++) begin
         logic [VW-1:0] e;
         logic [31:0] t_exp;
         e = VECS[v];
         @(negedge clk);
         sof_valid = 1'b1; sof_port = e[103:101]; t_exp = m_ns;
         @(negedge clk);
         sof_valid = 1'b0;
         hdr_valid = 1'b1; hdr_port = e[103:101]; hdr_dmac = e[100:53]; hdr_etype = e[52:37];
         @(negedge clk);
         hdr_valid = 1'b0;
         chk(fwd_valid == 1'b1, "R4 fwd_valid", 64'(fwd_valid), 1);
         chk(fwd_hit == e[36], "R1 R3 hit", 64'(fwd_hit), 64'(e[36]));
         if (e[36]) chk(fwd_entry == e[35:33], "R3 entry", 64'(fwd_entry), 64'(e[35:33]));
         chk(fwd_vec == e[32:1], "R4 vector", 64'(fwd_vec), 64'(e[32:1]));
         chk(rpt_valid == e[0], "R5 R6 stamp", 64'(rpt_valid), 64'(e[0]));
         if (e[0]) begin
            chk(rpt_port == e[103:101], "R8 port", 64'(rpt_port), 64'(e[103:101]));
            chk(rpt_time == t_exp, "R8 time", 64'(rpt_time), 64'(t_exp));
         end
      end

      // R10: hold while not ready, drop a second stamp
      @(negedge clk);
      rpt_ready = 1'b0;
      sof_valid = 1'b1; sof_port = 3'd0; t_a = m_ns;
      @(negedge clk);
      sof_valid = 1'b0;
      hdr_valid = 1'b1; hdr_port = 3'd0; hdr_dmac = 48'h1; hdr_etype = 16'h88F7;
      @(negedge clk);
      hdr_valid = 1'b0;
      chk(rpt_valid && rpt_time == t_a, "R10 first report", 64'(rpt_time), 64'(t_a));
      repeat (3) @(negedge clk);
      chk(rpt_valid && rpt_time == t_a, "R10 held report", 64'(rpt_time), 64'(t_a));
      sof_valid = 1'b1; sof_port = 3'd1; t_b = m_ns;
      @(negedge clk);
      sof_valid = 1'b0;
      hdr_valid = 1'b1; hdr_port = 3'd1;
      @(negedge clk);
      hdr_valid = 1'b0;
      chk(rpt_valid && rpt_port == 3'd0 && rpt_time == t_a, "R10 dropped stamp", 64'(rpt_time), 64'(t_a));

      // R11: accept and new stamp in the same cycle
      rpt_ready = 1'b1;
      hdr_valid = 1'b1; hdr_port = 3'd1;
      @(negedge clk);
      hdr_valid = 1'b0;
      chk(rpt_valid && rpt_port == 3'd1, "R11 new port", 64'(rpt_port), 1);
      chk(rpt_time == t_b, "R11 new time", 64'(rpt_time), 64'(t_b));
      @(negedge clk);
      chk(!rpt_valid, "R10 cleared on accept", 64'(rpt_valid), 0);

      // R7: report enable off
      wr(6'd5, 64'h0);
      @(negedge clk);
      hdr_valid = 1'b1; hdr_port = 3'd0; hdr_etype = 16'h88F7;
      @(negedge clk);
      hdr_valid = 1'b0;
      chk(fwd_hit && fwd_vec == 32'h100, "R7 forwarding kept", 64'(fwd_vec), 64'h100);
      chk(!rpt_valid, "R7 no report", 64'(rpt_valid), 0);
      wr(6'd5, 64'h1);

      // R9: stamps either side of the wrap
      while (m_ns != 32'd180) @(negedge clk);
      sof_valid = 1'b1; sof_port = 3'd0;
      @(negedge clk);
      chk(m_ns == 0, "R9 model wrap", 64'(m_ns), 0);
      sof_port = 3'd1;
      hdr_valid = 1'b1; hdr_port = 3'd0; hdr_etype = 16'h88F7;
      @(negedge clk);
      sof_valid = 1'b0;
      hdr_port = 3'd1;
      chk(rpt_valid && rpt_time == 32'd180, "R9 last before wrap", 64'(rpt_time), 180);
      @(negedge clk);
      hdr_valid = 1'b0;
      chk(rpt_valid && rpt_port == 3'd1 && rpt_time == 32'd0, "R9 wrapped to zero", 64'(rpt_time), 0);

      @(negedge clk);
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule